// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives the command line of an SD/MMC card. A single write of a command word and a 32-bit argument starts a transaction. The engine builds a 48-bit token, protected by a 7-bit CRC, and shifts it out on the command line at the card clock rate. The token can be followed by a short (48-bit) or long (136-bit) response from the card. The engine checks the CRC of that response, keeps the payload and raises sticky status flags. Software clears those flags by writing a mask of ones to a separate clear strobe.

A built-in divider makes the card clock from the source clock. The card clock period is the 8-bit divider value plus two source cycles. A bypass control passes the source clock straight through. A power-save control stops the card clock whenever no command is in flight. The engine changes the command line only on falling card-clock edges and samples the card's reply only on rising edges. Between commands it leaves the line released and high.

The interface is register-like rather than streaming. A command write is accepted only when the engine is idle, and the block applies no back-pressure. Software polls `cmd_active` or the flags before it issues the next command.

Top module: `sdcmd_engine`

## Requirements
- R1: A pulse on `cmd_wr` starts a command only if `cmd_word[10]` (enable) is 1 and the engine is idle. `cmd_active` is high from the cycle after acceptance until the transaction ends. A write with `cmd_word[10]`=0 does nothing: `cmd_active` and `cmd_oe` stay low.
- R2: The token is sent MSB first, one bit per falling card-clock edge, in this order: a 0, a 1, the index `cmd_word[5:0]`, the 32-bit argument, CRC7 and a final 1. The CRC7 uses polynomial x^7+x^3+1 with a zero initial value, taken over the first 40 token bits. When the token is not being driven, `cmd_oe` is 0 and `cmd_out` is 1.
- R3: The response type is `cmd_word[7:6]`. With type 00 or 10, the engine sets `flag_sent` when the token has been sent and returns to idle without waiting for a reply.
- R4: With type 01, a 48-bit reply follows. If its CRC7 over the first 40 bits matches, `flag_rsp_ok` is set. `rsp_index` then holds reply bits 45:40, `rsp_data[127:96]` holds reply bits 39:8, and `rsp_data[95:0]` is zero.
- R5: With type 11, a 136-bit reply follows. The CRC7 covers the 120 bits after the 8-bit header (start, transmission bit and six reserved bits). If the CRC matches, `flag_rsp_ok` is set. `rsp_data` then holds the last 128 reply bits (word 0 in bits 127:96), and `rsp_index` reads 6'h3F.
- R6: A reply whose CRC does not match sets `flag_crc_fail` and leaves `flag_rsp_ok` clear.
- R7: The reply start bit (a 0) is looked for on up to 64 rising card-clock edges after the token. A start bit on the 64th edge is still accepted. If none has come by then, `flag_timeout` is set.
- R8: The flags are sticky. `clr_wr` with `clr_bits` clears each flag whose bit is 1 and leaves the others alone. The bit order is 0 sent, 1 rsp_ok, 2 crc_fail, 3 timeout. A flag being set in the same cycle wins over its clear.
- R9: A command write while a transaction is active is ignored. The token in progress is unchanged, and no second command follows.
- R10: With the clock enabled and bypass off, `card_clk` has a period of `div_val`+2 source cycles.
- R11: With bypass on, `card_clk` has one rising edge per source cycle.
- R12: With `clk_en`=0, or with `clk_pwrsave`=1 while idle, `card_clk` has no edges. In power-save mode the clock runs during a command, and the command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 11 | [5:0] index, [7:6] response type, [10] enable |
| cmd_arg | input | 32 | Command argument |
| clr_wr | input | 1 | Flag clear strobe |
| clr_bits | input | 4 | Flags to clear (ones clear) |
| div_val | input | 8 | Card clock divider |
| clk_en | input | 1 | Card clock enable |
| clk_bypass | input | 1 | Pass source clock to card |
| clk_pwrsave | input | 1 | Stop card clock when idle |
| card_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line from card |
| cmd_active | output | 1 | Transaction in progress |
| flag_sent | output | 1 | Sent, no reply expected |
| flag_rsp_ok | output | 1 | Reply received, CRC good |
| flag_crc_fail | output | 1 | Reply CRC mismatch |
| flag_timeout | output | 1 | No reply start bit in window |
| rsp_index | output | 6 | Index field of last reply |
| rsp_data | output | 128 | Payload of last reply |

## Verification
The bench acts as a card model and goes after the edges of the 64-clock reply window. It places the start bit on the 64th and then the 65th rising edge. A counter that is off by one accepts the late bit or times out the on-time one. Long replies check the CRC coverage: a design that wrongly includes the reserved header bits reports a CRC failure on a good reply. A command written halfway through a token must leave the captured token intact, and a design without the busy guard corrupts the token or sends a second one. The clock tests count card-clock edges for a given divider, for bypass and for the gated modes, which catches a period of divider+1 and a clock left running while idle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } cmd_state_e;

  localparam int NUM_FLAGS     = 4;
  localparam int FLAG_SENT     = 0;
  localparam int FLAG_RSP_OK   = 1;
  localparam int FLAG_CRC_FAIL = 2;
  localparam int FLAG_TMO      = 3;

  localparam int CRC_W = 7;

  // One serial step of CRC7, polynomial x^7 + x^3 + 1.
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             pwrsave_i,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             card_clk_o
);
  localparam int CNT_W = DIV_W + 1;

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;
  logic             clk_q;

  assign run    = en_i && (!pwrsave_i || busy_i);
  assign period = CNT_W'(div_i) + CNT_W'(2);
  assign half   = period >> 1;

  assign fall_o = run && (bypass_i || (cnt == '0));
  assign rise_o = run && (bypass_i || (cnt == half));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (!run || bypass_i) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt <= (cnt >= period - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
      if (fall_o) clk_q <= 1'b0;
      if (rise_o) clk_q <= 1'b1;
    end
  end

  assign card_clk_o = bypass_i ? (clk & run) : clk_q;

  AST_STILL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!clk_q && cnt == '0)); // R12

endmodule

// File: rtl/sdcmd_flags.sv
module sdcmd_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  import sdcmd_pkg::*;

  logic [N-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;

  AST_OK_XOR_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i[FLAG_RSP_OK] && set_i[FLAG_CRC_FAIL])); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R8

endmodule

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm #(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int RSP_W    = 128,
  parameter int TMO_CLKS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  cmd_wr_i,
  input  logic [IDX_W+4:0]      cmd_word_i,
  input  logic [ARG_W-1:0]      cmd_arg_i,
  input  logic                  cmd_i,
  output logic                  active_o,
  output logic                  cmd_o,
  output logic                  cmd_oe_o,
  output logic [3:0]            set_o,
  output logic [IDX_W-1:0]      rsp_index_o,
  output logic [RSP_W-1:0]      rsp_data_o
);
  import sdcmd_pkg::*;

  localparam int HDR_W       = 2 + IDX_W + ARG_W;
  localparam int TOK_LEN     = HDR_W + CRC_W + 1;
  localparam int LONG_LEN    = 8 + RSP_W;
  localparam int SHORT_FIRST = 2;
  localparam int LONG_FIRST  = 9;
  localparam int BIT_W       = $clog2(LONG_LEN + 1);
  localparam int TMO_W       = $clog2(TMO_CLKS + 1);
  localparam int EN_POS      = IDX_W + 4;

  function automatic logic [CRC_W-1:0] hdr_crc(input logic [HDR_W-1:0] v);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = HDR_W - 1; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

  cmd_state_e         state;
  logic [TOK_LEN-1:0] tx_sr;
  logic [BIT_W-1:0]   tx_left;
  logic               want_rsp;
  logic               long_q;
  logic [TMO_W-1:0]   tmo;
  logic [BIT_W-1:0]   rx_n;
  logic [CRC_W-1:0]   crc;
  logic [RSP_W-1:0]   rx_sr;
  logic [3:0]         set_q;
  logic               cmd_q;

  logic [IDX_W-1:0]   idx;
  logic [1:0]         rtype;
  logic               start;
  logic [HDR_W-1:0]   hdr;
  logic [BIT_W-1:0]   bit_no;
  logic [BIT_W-1:0]   rx_len;
  logic [BIT_W-1:0]   rx_first;
  logic [RSP_W-1:0]   sr_next;

  assign idx      = cmd_word_i[IDX_W-1:0];
  assign rtype    = cmd_word_i[IDX_W+1:IDX_W];
  assign start    = cmd_wr_i && cmd_word_i[EN_POS] && (state == ST_IDLE);
  assign hdr      = {2'b01, idx, cmd_arg_i};
  assign bit_no   = rx_n + BIT_W'(1);
  assign rx_len   = long_q ? BIT_W'(LONG_LEN) : BIT_W'(TOK_LEN);
  assign rx_first = long_q ? BIT_W'(LONG_FIRST) : BIT_W'(SHORT_FIRST);
  assign sr_next  = {rx_sr[RSP_W-2:0], cmd_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tx_sr       <= '0;
      tx_left     <= '0;
      want_rsp    <= 1'b0;
      long_q      <= 1'b0;
      tmo         <= '0;
      rx_n        <= '0;
      crc         <= '0;
      rx_sr       <= '0;
      set_q       <= '0;
      cmd_q       <= 1'b1;
      rsp_index_o <= '0;
      rsp_data_o  <= '0;
    end else begin
      set_q <= '0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            tx_sr    <= {hdr, hdr_crc(hdr), 1'b1};
            tx_left  <= BIT_W'(TOK_LEN);
            want_rsp <= rtype[0];
            long_q   <= &rtype;
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fall_i) begin
            if (tx_left != '0) begin
              cmd_q   <= tx_sr[TOK_LEN-1];
              tx_sr   <= {tx_sr[TOK_LEN-2:0], 1'b0};
              tx_left <= tx_left - BIT_W'(1);
            end else begin
              cmd_q <= 1'b1;
              if (want_rsp) begin
                state <= ST_WAIT;
                tmo   <= '0;
              end else begin
                state            <= ST_IDLE;
                set_q[FLAG_SENT] <= 1'b1;
              end
            end
          end
        end
        ST_WAIT: begin
          if (rise_i) begin
            if (!cmd_i) begin
              state <= ST_RECV;
              rx_n  <= BIT_W'(1);
              crc   <= '0;
              rx_sr <= '0;
            end else if (tmo == TMO_W'(TMO_CLKS - 1)) begin
              state           <= ST_IDLE;
              set_q[FLAG_TMO] <= 1'b1;
            end else begin
              tmo <= tmo + TMO_W'(1);
            end
          end
        end
        ST_RECV: begin
          if (rise_i) begin
            rx_n  <= bit_no;
            rx_sr <= sr_next;
            if (bit_no == rx_len) begin
              state <= ST_IDLE;
              if (crc == '0) set_q[FLAG_RSP_OK]   <= 1'b1;
              else           set_q[FLAG_CRC_FAIL] <= 1'b1;
              if (long_q) begin
                rsp_index_o <= '1;
                rsp_data_o  <= sr_next;
              end else begin
                rsp_index_o <= sr_next[ARG_W+8+IDX_W-1:ARG_W+8];
                rsp_data_o  <= {sr_next[ARG_W+7:8], {(RSP_W-ARG_W){1'b0}}};
              end
            end else if (bit_no >= rx_first) begin
              crc <= crc7_step(crc, cmd_i);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign active_o = (state != ST_IDLE);
  assign cmd_oe_o = (state == ST_SEND);
  assign cmd_o    = cmd_q;
  assign set_o    = set_q;

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(cmd_o)); // R2

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (tmo < TMO_W'(TMO_CLKS))); // R7

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && state == ST_SEND && !fall_i) |=> $stable(tx_sr)); // R9

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int DIV_W    = 8,
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int RSP_W    = 128,
  parameter int TMO_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [IDX_W+4:0]  cmd_word,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              clr_wr,
  input  logic [3:0]        clr_bits,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              clk_en,
  input  logic              clk_bypass,
  input  logic              clk_pwrsave,
  output logic              card_clk,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  output logic              cmd_active,
  output logic              flag_sent,
  output logic              flag_rsp_ok,
  output logic              flag_crc_fail,
  output logic              flag_timeout,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [RSP_W-1:0]  rsp_data
);
  import sdcmd_pkg::*;

  logic                 rise;
  logic                 fall;
  logic                 active;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] clr_vec;

  assign clr_vec = clr_wr ? clr_bits : '0;

  sdcmd_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (clk_en),
    .bypass_i   (clk_bypass),
    .pwrsave_i  (clk_pwrsave),
    .busy_i     (active),
    .div_i      (div_val),
    .rise_o     (rise),
    .fall_o     (fall),
    .card_clk_o (card_clk)
  );

  sdcmd_fsm #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .RSP_W(RSP_W), .TMO_CLKS(TMO_CLKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .fall_i      (fall),
    .cmd_wr_i    (cmd_wr),
    .cmd_word_i  (cmd_word),
    .cmd_arg_i   (cmd_arg),
    .cmd_i       (cmd_in),
    .active_o    (active),
    .cmd_o       (cmd_out),
    .cmd_oe_o    (cmd_oe),
    .set_o       (set_vec),
    .rsp_index_o (rsp_index),
    .rsp_data_o  (rsp_data)
  );

  sdcmd_flags #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  assign cmd_active    = active;
  assign flag_sent     = flags[FLAG_SENT];
  assign flag_rsp_ok   = flags[FLAG_RSP_OK];
  assign flag_crc_fail = flags[FLAG_CRC_FAIL];
  assign flag_timeout  = flags[FLAG_TMO];

  AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out); // R2

  AST_ACTIVE_WHILE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_active); // R1

endmodule

// File: tb/tb_sdcmd_engine.sv
module tb_sdcmd_engine;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [10:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic         clr_wr = 1'b0;
  logic [3:0]   clr_bits = '0;
  logic [7:0]   div_val = 8'd2;
  logic         clk_en = 1'b1;
  logic         clk_bypass = 1'b0;
  logic         clk_pwrsave = 1'b0;
  logic         card_clk;
  logic         cmd_out;
  logic         cmd_oe;
  logic         cmd_in = 1'b1;
  logic         cmd_active;
  logic         flag_sent;
  logic         flag_rsp_ok;
  logic         flag_crc_fail;
  logic         flag_timeout;
  logic [5:0]   rsp_index;
  logic [127:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int unsigned clk_edges = 0;

  always #10 clk = ~clk;
  always @(posedge card_clk) clk_edges <= clk_edges + 1;

  sdcmd_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .clr_wr(clr_wr), .clr_bits(clr_bits), .div_val(div_val), .clk_en(clk_en),
    .clk_bypass(clk_bypass), .clk_pwrsave(clk_pwrsave), .card_clk(card_clk),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .cmd_active(cmd_active),
    .flag_sent(flag_sent), .flag_rsp_ok(flag_rsp_ok), .flag_crc_fail(flag_crc_fail),
    .flag_timeout(flag_timeout), .rsp_index(rsp_index), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  // CRC7, x^7+x^3+1, zero start, over the low n bits of v, MSB first
  function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n);
    logic [6:0] r;
    logic top;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      top = r[6] ^ v[i];
      r = {r[5:0], 1'b0};
      if (top) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_token(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, ref_crc({96'b0, h}, 40), 1'b1};
  endfunction

  task automatic issue(input logic en, input logic [1:0] rt, input logic [5:0] idx,
                       input logic [31:0] arg);
    @(negedge clk);
    cmd_word = {en, 2'b00, rt, idx};
    cmd_arg  = arg;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    clr_bits = m;
    clr_wr   = 1'b1;
    @(negedge clk);
    clr_wr   = 1'b0;
    @(negedge clk);
  endtask

  task automatic capture_token(output logic [47:0] tok);
    tok = '1;
    forever begin
      @(posedge card_clk);
      if (cmd_oe && cmd_out == 1'b0) break;
    end
    tok[47] = 1'b0;
    for (int i = 46; i >= 0; i--) begin
      @(posedge card_clk);
      tok[i] = cmd_out;
    end
  endtask

  task automatic card_reply(input logic [135:0] bits, input int len, input int dly);
    repeat (dly) @(negedge card_clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = bits[i];
      @(negedge card_clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!cmd_active) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 reset line", {cmd_oe, cmd_out}, 2'b01);
    check("R1 reset active", cmd_active, 0);
    check("R8 reset flags", {flag_timeout, flag_crc_fail, flag_rsp_ok, flag_sent}, 0);
  endtask

  task automatic t_no_rsp();
    logic [47:0] tok;
    issue(1'b1, 2'b00, 6'd17, 32'hA5C3_0F12);
    check("R1 active after accept", cmd_active, 1);
    capture_token(tok);
    check("R2 token", tok, ref_token(6'd17, 32'hA5C3_0F12));
    wait_idle();
    check("R3 sent flag", flag_sent, 1);
    check("R3 no reply flags", {flag_rsp_ok, flag_timeout}, 0);
  endtask

  task automatic t_disabled();
    issue(1'b0, 2'b00, 6'd5, 32'h1);
    repeat (30) @(negedge clk);
    check("R1 disabled write ignored", {cmd_active, cmd_oe}, 0);
  endtask

  task automatic t_timeout();
    logic [47:0] tok;
    issue(1'b1, 2'b01, 6'd8, 32'h0000_01AA);
    capture_token(tok);
    wait_idle();
    check("R7 timeout flag", flag_timeout, 1);
    check("R7 no rsp_ok", flag_rsp_ok, 0);
  endtask

  task automatic t_clear();
    clear(4'b0001);
    check("R8 sent cleared", flag_sent, 0);
    check("R8 timeout kept", flag_timeout, 1);
    clear(4'b1000);
    check("R8 timeout cleared", flag_timeout, 0);
  endtask

  task automatic t_type10();
    logic [47:0] tok;
    issue(1'b1, 2'b10, 6'd0, 32'h0);
    capture_token(tok);
    check("R2 token idx0", tok, ref_token(6'd0, 32'h0));
    wait_idle();
    check("R3 type10 sent", flag_sent, 1);
    clear(4'b1111);
  endtask

  task automatic short_reply(input int dly, input logic flip, input logic [5:0] ridx,
                             input logic [31:0] rarg);
    logic [47:0]  tok;
    logic [135:0] r;
    logic [39:0]  h;
    h = {2'b00, ridx, rarg};
    r = {88'b0, h, ref_crc({96'b0, h}, 40) ^ {6'b0, flip}, 1'b1};
    issue(1'b1, 2'b01, 6'd13, 32'h1234_5678);
    capture_token(tok);
    card_reply(r, 48, dly);
    wait_idle();
  endtask

  task automatic t_short_good();
    short_reply(5, 1'b0, 6'd13, 32'h0000_0900);
    check("R4 rsp_ok", {flag_rsp_ok, flag_crc_fail}, 2'b10);
    check("R4 rsp_index", rsp_index, 6'd13);
    check("R4 rsp_data", rsp_data, {32'h0000_0900, 96'b0});
    clear(4'b1111);
  endtask

  task automatic t_short_bad();
    short_reply(3, 1'b1, 6'd13, 32'hCAFE_0001);
    check("R6 crc_fail", {flag_rsp_ok, flag_crc_fail}, 2'b01);
    clear(4'b1111);
  endtask

  task automatic t_long();
    logic [47:0]  tok;
    logic [119:0] d;
    logic [135:0] r;
    d = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 24'h55AA33};
    r = {2'b00, 6'h3F, d, ref_crc({16'b0, d}, 120), 1'b1};
    issue(1'b1, 2'b11, 6'd2, 32'h0);
    capture_token(tok);
    card_reply(r, 136, 2);
    wait_idle();
    check("R5 long rsp_ok", {flag_rsp_ok, flag_crc_fail}, 2'b10);
    check("R5 long data", rsp_data, r[127:0]);
    check("R5 long index", rsp_index, 6'h3F);
    clear(4'b1111);
  endtask

  task automatic t_window();
    short_reply(64, 1'b0, 6'd13, 32'h0000_0077);
    check("R7 start on 64th edge accepted", {flag_rsp_ok, flag_timeout}, 2'b10);
    clear(4'b1111);
    short_reply(65, 1'b0, 6'd13, 32'h0000_0077);
    check("R7 start on 65th edge late", {flag_rsp_ok, flag_timeout}, 2'b01);
    clear(4'b1111);
  endtask

  task automatic t_busy_write();
    logic [47:0] tok;
    int seen;
    issue(1'b1, 2'b00, 6'd21, 32'h0F0F_F0F0);
    fork
      capture_token(tok);
      begin
        repeat (40) @(negedge clk);
        cmd_word = {1'b1, 2'b00, 2'b00, 6'd40};
        cmd_arg  = 32'hFFFF_0000;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
      end
    join
    check("R9 token unchanged", tok, ref_token(6'd21, 32'h0F0F_F0F0));
    wait_idle();
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (cmd_active || cmd_oe) seen = 1;
    end
    check("R9 no second command", seen, 0);
    clear(4'b1111);
  endtask

  task automatic count_edges(input int cycles, output int unsigned n);
    int unsigned s;
    @(negedge clk);
    s = clk_edges;
    repeat (cycles) @(negedge clk);
    n = clk_edges - s;
  endtask

  task automatic t_clocks();
    int unsigned n;
    div_val = 8'd3;
    repeat (10) @(negedge clk);
    count_edges(50, n);
    check("R10 divider 3 period 5", n, 10);
    div_val = 8'd2;
    repeat (10) @(negedge clk);
    count_edges(40, n);
    check("R10 divider 2 period 4", n, 10);
    clk_bypass = 1'b1;
    repeat (4) @(negedge clk);
    count_edges(40, n);
    check("R11 bypass rate", n, 40);
    clk_bypass = 1'b0;
    clk_en = 1'b0;
    repeat (4) @(negedge clk);
    count_edges(40, n);
    check("R12 disabled clock still", n, 0);
    clk_en = 1'b1;
    clk_pwrsave = 1'b1;
    repeat (4) @(negedge clk);
    count_edges(40, n);
    check("R12 powersave idle still", n, 0);
    issue(1'b1, 2'b00, 6'd9, 32'h0000_0042);
    wait_idle();
    check("R12 powersave command done", flag_sent, 1);
    clk_pwrsave = 1'b0;
    clear(4'b1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_rsp();
    t_disabled();
    t_timeout();
    t_clear();
    t_type10();
    t_short_good();
    t_short_bad();
    t_long();
    t_window();
    t_busy_write();
    t_clocks();
    finish_sim();
  end

endmodule